// File: doc/BRIEF.md
# Dual-Die Memory Bus Steering Controller

This block sits on the host side of a package that stacks two memories on one shared address, data and control bus. One of them is a 1M x 16 pseudo-static RAM. The other is a 4 Mbit static RAM that can be wired by a pin as 256K x 16 or as 512K x 8. A host issues one request at a time. Each request carries a target die, a read or write flag, an address, write data and two byte enables. The controller turns the request into a legal sequence of pin levels. It first selects the addressed die with the address and strobes settled. Then it opens a read window on the output enable, or a write window on the write enable with the host data driver behind it. Finally it releases the die. It returns one response per access.

The two dies use different chip-select polarities. The controller keeps the idle die fully deselected whenever the other die is in use. It also places the byte lanes correctly for each width. A request that has no legal pin encoding is answered with an error pulse and leaves the bus untouched. The static RAM width is a configuration input. The controller copies it to the width pin only between accesses.

Top module: `dual_die_bus_ctrl`

## Requirements
- R1: Idle state for both dies: pseudo-static enable `mem_psr_ce_n` high, and both static RAM enables off (`mem_sr_ce1_n` high and `mem_sr_ce2` low). A pseudo-static access drives `mem_psr_ce_n` low. A static RAM access drives `mem_sr_ce1_n` low and `mem_sr_ce2` high. No other enable combination ever appears.
- R2: The two dies are never selected in the same cycle. When a request for the other die is already waiting, its enable is asserted on the clock edge that follows the edge releasing the previous die.
- R3: The pseudo-static standby pin `mem_psr_mode` is high in every cycle after reset.
- R4: Static RAM byte mode is selected by `sram_wide`=0, which drives `mem_sr_cio` low. A request in this mode uses host byte address bits [18:0]. Bit 0 goes on `mem_sr_sa` and bits [18:1] go on `mem_a[17:0]`, with `mem_a[19:18]` low. Only the lower strobe is asserted (`mem_ub_n` high). Data moves on lanes [7:0] only, and `rsp_rdata[15:8]` reads zero.
- R5: Word mode covers the pseudo-static RAM (20-bit word address) and the static RAM with `sram_wide`=1 (18-bit word address, `mem_sr_sa` low). `req_be[0]` drives `mem_lb_n` low for lanes [7:0], and `req_be[1]` drives `mem_ub_n` low for lanes [15:8]. Only the enabled lanes are written. On a read, lanes that are not enabled return zero.
- R6: `mem_we_n` is low only while a die is selected and at least one strobe is low. `mem_oe_n` stays high while `mem_we_n` is low. `mem_dq_oe` rises only when `mem_we_n` has already been low for a cycle, and it is never high while `mem_oe_n` is low.
- R7: `mem_a` and `mem_sr_sa` change only on an edge where `mem_we_n` is high both before and after the edge.
- R8: `mem_oe_n` is low only during a read, with a die selected and `mem_we_n` high. Every accepted access produces exactly one `rsp_valid` pulse. For a read, it carries the data sampled from `mem_dq_i` at the end of the read window. For a write, it carries zero.
- R9: Some requests have no legal pin encoding and are rejected. These are: `req_be`=00; byte mode with `req_be` other than 01; a word-mode static RAM address with bit 18 or 19 set; a byte-mode address with bit 19 set. A rejected request produces a one-cycle `rsp_err` pulse on the cycle after acceptance, no `rsp_valid`, and no change on any memory pin.
- R10: `mem_sr_cio` copies `sram_wide` only on cycles where the controller is idle. It holds its value while any die is selected.
- R11: After reset, `req_ready` is high, `mem_oe_n` and `mem_we_n` are high, `mem_dq_oe` is low, and both dies are in the idle state.
- R12: The selected die's enable precedes the first `mem_oe_n` or `mem_we_n` assertion by SETUP_CYC cycles. `mem_oe_n` stays low for READ_CYC cycles. `mem_we_n` stays low for WRITE_CYC+1 cycles. The defaults are 1, 3 and 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request taken this cycle |
| req_tgt | input | 1 | 0 pseudo-static RAM, 1 static RAM |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | ADDR_W | Word or byte address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables, bit 0 lanes [7:0] |
| sram_wide | input | 1 | Static RAM width config, 1 word, 0 byte |
| rsp_valid | output | 1 | Access finished |
| rsp_rdata | output | 16 | Read data, unused lanes zero |
| rsp_err | output | 1 | Request rejected |
| mem_a | output | ADDR_W | Shared address pins |
| mem_sr_sa | output | 1 | Static RAM spare address pin |
| mem_psr_ce_n | output | 1 | Pseudo-static chip enable, active low |
| mem_psr_mode | output | 1 | Pseudo-static standby select, held high |
| mem_sr_ce1_n | output | 1 | Static RAM enable, active low |
| mem_sr_ce2 | output | 1 | Static RAM enable, active high |
| mem_sr_cio | output | 1 | Static RAM width pin |
| mem_oe_n | output | 1 | Shared output enable |
| mem_we_n | output | 1 | Shared write enable |
| mem_lb_n | output | 1 | Lower byte strobe |
| mem_ub_n | output | 1 | Upper byte strobe |
| mem_dq_o | output | 16 | Data toward the memories |
| mem_dq_oe | output | 1 | Host data driver enable |
| mem_dq_i | input | 16 | Data from the memories |

## Verification
The bench targets the die handover. It queues a static RAM request behind a pseudo-static read and measures the gap between the two enables. A controller that overlapped the dies would fail this, and so would one that inserted extra idle cycles. Random traffic hits every rejection rule, including byte enables left empty, word lanes requested in byte mode, and addresses one bit too wide. A design that let any of these through would toggle pins or corrupt the memory model. Byte mode is checked at the pins for spare-address placement and for the upper strobe staying off, since a shifted address would alias bytes. The width input is flipped in the middle of an access to catch a width pin that follows it while a die is selected. Unused lanes are filled with junk by the memory model, so a wrong lane mask or an early data capture shows up in the returned data.

// File: rtl/dual_die_bus_ctrl.sv
module dual_die_bus_ctrl #(
  parameter int ADDR_W    = 20,
  parameter int SR_AW     = 18,
  parameter int SETUP_CYC = 1,
  parameter int READ_CYC  = 3,
  parameter int WRITE_CYC = 2
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_tgt,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [15:0]       req_wdata,
  input  logic [1:0]        req_be,
  input  logic              sram_wide,
  output logic              rsp_valid,
  output logic [15:0]       rsp_rdata,
  output logic              rsp_err,
  output logic [ADDR_W-1:0] mem_a,
  output logic              mem_sr_sa,
  output logic              mem_psr_ce_n,
  output logic              mem_psr_mode,
  output logic              mem_sr_ce1_n,
  output logic              mem_sr_ce2,
  output logic              mem_sr_cio,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic              mem_lb_n,
  output logic              mem_ub_n,
  output logic [15:0]       mem_dq_o,
  output logic              mem_dq_oe,
  input  logic [15:0]       mem_dq_i
);
  localparam int MAXC  = (SETUP_CYC > READ_CYC) ?
                         ((SETUP_CYC > WRITE_CYC) ? SETUP_CYC : WRITE_CYC) :
                         ((READ_CYC > WRITE_CYC) ? READ_CYC : WRITE_CYC);
  localparam int CNT_W = (MAXC < 2) ? 1 : $clog2(MAXC);
  localparam int PAD   = ADDR_W - SR_AW;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_READ, ST_WEN, ST_WDAT, ST_WHOLD
  } st_t;

  st_t              state;
  logic [CNT_W-1:0] cnt;
  logic             wr_q;

  logic              byte_req, bad_be, bad_addr, reject;
  logic [ADDR_W-1:0] pin_a;
  logic              pin_sa;
  logic [15:0]       pin_d;

  assign byte_req = req_tgt & ~sram_wide;
  assign bad_be   = (req_be == 2'b00) | (byte_req & (req_be != 2'b01));
  assign bad_addr = req_tgt & (sram_wide ? (|req_addr[ADDR_W-1:SR_AW])
                                         : (|req_addr[ADDR_W-1:SR_AW+1]));
  assign reject   = bad_be | bad_addr;

  always_comb begin
    pin_sa = 1'b0;
    pin_d  = req_wdata;
    if (!req_tgt) begin
      pin_a = req_addr;
    end else if (sram_wide) begin
      pin_a = {{PAD{1'b0}}, req_addr[SR_AW-1:0]};
    end else begin
      pin_a  = {{PAD{1'b0}}, req_addr[SR_AW:1]};
      pin_sa = req_addr[0];
      pin_d  = {8'h00, req_wdata[7:0]};
    end
  end

  assign req_ready    = (state == ST_IDLE);
  assign mem_psr_mode = 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      cnt          <= '0;
      wr_q         <= 1'b0;
      mem_a        <= '0;
      mem_sr_sa    <= 1'b0;
      mem_psr_ce_n <= 1'b1;
      mem_sr_ce1_n <= 1'b1;
      mem_sr_ce2   <= 1'b0;
      mem_sr_cio   <= 1'b0;
      mem_oe_n     <= 1'b1;
      mem_we_n     <= 1'b1;
      mem_lb_n     <= 1'b1;
      mem_ub_n     <= 1'b1;
      mem_dq_o     <= '0;
      mem_dq_oe    <= 1'b0;
      rsp_valid    <= 1'b0;
      rsp_err      <= 1'b0;
      rsp_rdata    <= '0;
    end else begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      case (state)
        ST_IDLE: begin
          mem_sr_cio <= sram_wide;
          if (req_valid) begin
            if (reject) begin
              rsp_err <= 1'b1;
            end else begin
              mem_a        <= pin_a;
              mem_sr_sa    <= pin_sa;
              mem_lb_n     <= ~req_be[0];
              mem_ub_n     <= ~req_be[1];
              mem_dq_o     <= pin_d;
              mem_psr_ce_n <= req_tgt;
              mem_sr_ce1_n <= ~req_tgt;
              mem_sr_ce2   <= req_tgt;
              wr_q         <= req_write;
              cnt          <= CNT_W'(SETUP_CYC - 1);
              state        <= ST_SETUP;
            end
          end
        end
        ST_SETUP: begin
          if (cnt == '0) begin
            if (wr_q) begin
              mem_we_n <= 1'b0;
              state    <= ST_WEN;
            end else begin
              mem_oe_n <= 1'b0;
              cnt      <= CNT_W'(READ_CYC - 1);
              state    <= ST_READ;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_READ: begin
          if (cnt == '0) begin
            rsp_rdata    <= {mem_ub_n ? 8'h00 : mem_dq_i[15:8],
                             mem_lb_n ? 8'h00 : mem_dq_i[7:0]};
            rsp_valid    <= 1'b1;
            mem_oe_n     <= 1'b1;
            mem_psr_ce_n <= 1'b1;
            mem_sr_ce1_n <= 1'b1;
            mem_sr_ce2   <= 1'b0;
            mem_lb_n     <= 1'b1;
            mem_ub_n     <= 1'b1;
            state        <= ST_IDLE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_WEN: begin
          mem_dq_oe <= 1'b1;
          cnt       <= CNT_W'(WRITE_CYC - 1);
          state     <= ST_WDAT;
        end
        ST_WDAT: begin
          if (cnt == '0) begin
            mem_we_n <= 1'b1;
            state    <= ST_WHOLD;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_WHOLD: begin
          mem_dq_oe    <= 1'b0;
          mem_psr_ce_n <= 1'b1;
          mem_sr_ce1_n <= 1'b1;
          mem_sr_ce2   <= 1'b0;
          mem_lb_n     <= 1'b1;
          mem_ub_n     <= 1'b1;
          rsp_rdata    <= '0;
          rsp_valid    <= 1'b1;
          state        <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dual_die_bus_ctrl_chk.sv
module dual_die_bus_ctrl_chk #(
  parameter int ADDR_W = 20
)(
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] mem_a,
  input logic              mem_sr_sa,
  input logic              mem_psr_ce_n,
  input logic              mem_sr_ce1_n,
  input logic              mem_sr_ce2,
  input logic              mem_sr_cio,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic              mem_lb_n,
  input logic              mem_ub_n,
  input logic              mem_dq_oe,
  input logic              rsp_valid,
  input logic              rsp_err
);
  logic psr_sel, sr_sel, any_sel;
  assign psr_sel = ~mem_psr_ce_n;
  assign sr_sel  = ~mem_sr_ce1_n & mem_sr_ce2;
  assign any_sel = psr_sel | sr_sel;

  // R2
  die_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(psr_sel && sr_sel));

  // R1
  sr_half_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_sr_ce1_n == mem_sr_ce2) |-> 1'b0) else $error("static RAM half-selected");

  // R6
  we_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (any_sel && !(mem_lb_n && mem_ub_n) && mem_oe_n));

  // R6
  drv_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> (!mem_we_n && !$past(mem_we_n) && mem_oe_n));

  // R6
  drv_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);

  // R7
  addr_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({mem_a, mem_sr_sa}) |-> (mem_we_n && $past(mem_we_n)));

  // R8
  oe_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (mem_we_n && any_sel));

  // R4
  byte_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_sel && !mem_sr_cio) |-> mem_ub_n);

  // R10
  cio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (any_sel && $past(any_sel)) |-> $stable(mem_sr_cio));

  // R9
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (!any_sel && !rsp_valid));
endmodule

bind dual_die_bus_ctrl dual_die_bus_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_a(mem_a), .mem_sr_sa(mem_sr_sa),
  .mem_psr_ce_n(mem_psr_ce_n), .mem_sr_ce1_n(mem_sr_ce1_n),
  .mem_sr_ce2(mem_sr_ce2), .mem_sr_cio(mem_sr_cio), .mem_oe_n(mem_oe_n),
  .mem_we_n(mem_we_n), .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n),
  .mem_dq_oe(mem_dq_oe), .rsp_valid(rsp_valid), .rsp_err(rsp_err)
);

// File: tb/tb_dual_die_bus_ctrl.sv
`timescale 1ns/1ps
module tb_dual_die_bus_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_tgt = 0, req_write = 0, sram_wide = 1;
  logic [19:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic req_ready, rsp_valid, rsp_err;
  logic [15:0] rsp_rdata;
  logic [19:0] mem_a;
  logic mem_sr_sa, mem_psr_ce_n, mem_psr_mode, mem_sr_ce1_n, mem_sr_ce2, mem_sr_cio;
  logic mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n, mem_dq_oe;
  logic [15:0] mem_dq_o;
  logic [15:0] mem_dq_i = 16'hEEEE;

  dual_die_bus_ctrl dut (.*);

  always #2 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] dflt(input int k);
    return k[15:0] ^ 16'h3C5A;
  endfunction

  logic [15:0] mem_m [int];
  logic [15:0] ref_m [int];

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int rsp_cnt = 0, err_cnt = 0, sel_cycles = 0;
  logic [15:0] last_rdata;
  int v_excl = 0, v_mode = 0, v_drv = 0, v_addr = 0, v_oe = 0, v_wr = 0, v_stby = 0, v_cio = 0;
  int psr_rel_cyc = -10, sr_sel_cyc = -20, sel_rise_cyc = 0, oe_fall_cyc = 0;
  int oe_run = 0, oe_len = 0, we_run = 0, we_len = 0;
  logic [19:0] snap_a; logic snap_sa, snap_ub, snap_cio;
  logic p_psr = 0, p_sr = 0, p_we = 1, p_dqoe = 0, p_oe = 1, p_cio = 0;
  logic [20:0] p_addr = '0;

  always @(negedge clk) begin
    logic psel, ssel;
    int k;
    psel = !mem_psr_ce_n;
    ssel = !mem_sr_ce1_n && mem_sr_ce2;
    if (rst_n) begin
      if (psel && ssel) v_excl++;
      if (!mem_psr_mode) v_mode++;
      if (!ssel && !(mem_sr_ce1_n && !mem_sr_ce2)) v_stby++;
      if (mem_dq_oe && !mem_oe_n) v_drv++;
      if (mem_dq_oe && !p_dqoe && !(p_we == 0 && mem_we_n == 0)) v_drv++;
      if ({mem_a, mem_sr_sa} != p_addr && !(mem_we_n && p_we)) v_addr++;
      if (!mem_oe_n && (!mem_we_n || !(psel || ssel))) v_oe++;
      if (!mem_we_n && (!(psel || ssel) || (mem_lb_n && mem_ub_n))) v_wr++;
      if ((psel || ssel) && (p_psr || p_sr) && mem_sr_cio != p_cio) v_cio++;
      if (psel || ssel) sel_cycles++;
      if (!psel && p_psr) psr_rel_cyc = cyc;
      if (ssel && !p_sr) sr_sel_cyc = cyc;
      if ((psel || ssel) && !(p_psr || p_sr)) sel_rise_cyc = cyc;
      if (!mem_oe_n && p_oe) oe_fall_cyc = cyc;
      if (!mem_oe_n) oe_run++; else if (oe_run != 0) begin oe_len = oe_run; oe_run = 0; end
      if (!mem_we_n) we_run++; else if (we_run != 0) begin we_len = we_run; we_run = 0; end
      if (ssel) begin snap_a = mem_a; snap_sa = mem_sr_sa; snap_ub = mem_ub_n; snap_cio = mem_sr_cio; end
      if (rsp_valid) begin rsp_cnt++; last_rdata = rsp_rdata; end
      if (rsp_err) err_cnt++;
      k = psel ? int'(mem_a) : (mem_sr_cio ? (32'h100000 | int'(mem_a[17:0]))
                                           : (32'h200000 | int'({mem_a[17:0], mem_sr_sa})));
      if ((psel || ssel) && !mem_we_n && mem_dq_oe) begin
        logic [15:0] w;
        w = mem_m.exists(k) ? mem_m[k] : dflt(k);
        if (!mem_lb_n) w[7:0] = mem_dq_o[7:0];
        if (!mem_ub_n) w[15:8] = mem_dq_o[15:8];
        mem_m[k] = w;
      end
      if ((psel || ssel) && !mem_oe_n && mem_we_n) begin
        logic [15:0] r;
        r = mem_m.exists(k) ? mem_m[k] : dflt(k);
        mem_dq_i = {(mem_ub_n || (ssel && !mem_sr_cio)) ? 8'hEE : r[15:8],
                    mem_lb_n ? 8'hEE : r[7:0]};
      end else mem_dq_i = 16'hEEEE;
    end
    p_psr = psel; p_sr = ssel; p_we = mem_we_n; p_dqoe = mem_dq_oe; p_oe = mem_oe_n;
    p_cio = mem_sr_cio; p_addr = {mem_a, mem_sr_sa};
  end

  function automatic bit exp_reject(input logic tgt, input logic wide, input logic [19:0] a, input logic [1:0] be);
    if (be == 2'b00) return 1;
    if (tgt && !wide && be != 2'b01) return 1;
    if (tgt && wide && a[19:18] != 0) return 1;
    if (tgt && !wide && a[19]) return 1;
    return 0;
  endfunction

  function automatic int host_key(input logic tgt, input logic wide, input logic [19:0] a);
    if (!tgt) return int'(a);
    if (wide) return 32'h100000 | int'(a[17:0]);
    return 32'h200000 | int'(a[18:0]);
  endfunction

  task automatic do_req(input logic tgt, input logic wr, input logic [19:0] a,
                        input logic [15:0] wd, input logic [1:0] be, input string tag);
    int r0, e0, s0, k;
    bit rej, got;
    logic [15:0] rv, ex;
    while (!req_ready) @(negedge clk);
    rej = exp_reject(tgt, sram_wide, a, be);
    k = host_key(tgt, sram_wide, a);
    rv = ref_m.exists(k) ? ref_m[k] : dflt(k);
    if (tgt && !sram_wide) ex = {8'h00, rv[7:0]};
    else ex = {be[1] ? rv[15:8] : 8'h00, be[0] ? rv[7:0] : 8'h00};
    r0 = rsp_cnt; e0 = err_cnt; s0 = sel_cycles;
    req_tgt = tgt; req_write = wr; req_addr = a; req_wdata = wd; req_be = be; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    got = 0;
    for (int i = 0; i < 60 && !got; i++) begin
      @(posedge clk);
      if (rsp_cnt != r0 || err_cnt != e0) got = 1;
    end
    @(negedge clk);
    @(negedge clk);
    if (rej) begin
      chk(err_cnt == e0 + 1 && rsp_cnt == r0, {"R9 reject ", tag}, err_cnt - e0, 1);
      chk(sel_cycles == s0, {"R9 quiet pins ", tag}, sel_cycles - s0, 0);
    end else begin
      chk(rsp_cnt == r0 + 1 && err_cnt == e0, {"R8 one response ", tag}, rsp_cnt - r0, 1);
      if (wr) begin
        if (tgt && !sram_wide) rv[7:0] = wd[7:0];
        else begin
          if (be[0]) rv[7:0] = wd[7:0];
          if (be[1]) rv[15:8] = wd[15:8];
        end
        ref_m[k] = rv;
      end else
        chk(last_rdata == ex, {tgt ? (sram_wide ? "R5 sram word read " : "R4 sram byte read ")
                                    : "R5 psram read ", tag}, last_rdata, ex);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int s0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R11 R1 reset state
    chk(req_ready && mem_oe_n && mem_we_n && !mem_dq_oe, "R11 reset idle", {req_ready, mem_oe_n, mem_we_n, mem_dq_oe}, 4'b1110);
    chk(mem_psr_ce_n && mem_sr_ce1_n && !mem_sr_ce2, "R1 reset standby", {mem_psr_ce_n, mem_sr_ce1_n, mem_sr_ce2}, 3'b110);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(mem_psr_mode, "R3 mode high", mem_psr_mode, 1);

    do_req(0, 1, 20'h00012, 16'hBEEF, 2'b11, "psr word wr");
    do_req(0, 0, 20'h00012, 16'h0, 2'b11, "psr word rd");
    // R12 read window timing
    chk(oe_len == 3 && oe_fall_cyc - sel_rise_cyc == 1, "R12 read window", {oe_len[15:0], 16'(oe_fall_cyc - sel_rise_cyc)}, {16'd3, 16'd1});
    do_req(0, 1, 20'h00012, 16'h1234, 2'b10, "psr upper wr");
    chk(we_len == 3, "R12 write window", we_len, 3);
    do_req(0, 0, 20'h00012, 16'h0, 2'b11, "psr after upper");
    do_req(0, 0, 20'h00012, 16'h0, 2'b01, "psr lower rd");
    sram_wide = 1;
    do_req(1, 1, 20'h3FFFF, 16'hA55A, 2'b11, "sr top word wr");
    do_req(1, 0, 20'h3FFFF, 16'h0, 2'b10, "sr top upper rd");
    sram_wide = 0;
    do_req(1, 1, 20'h50003, 16'h77C3, 2'b01, "sr byte wr");
    do_req(1, 0, 20'h50003, 16'h0, 2'b01, "sr byte rd");
    // R4 byte-mode pin mapping
    chk(snap_a == 20'h28001 && snap_sa && snap_ub && !snap_cio, "R4 byte pins",
        {snap_a, snap_sa, snap_ub, snap_cio}, {20'h28001, 3'b110});
    do_req(1, 0, 20'h00004, 16'h0, 2'b11, "byte word req");
    do_req(1, 1, 20'h80000, 16'h0, 2'b01, "byte addr too wide");
    sram_wide = 1;
    do_req(1, 0, 20'h40000, 16'h0, 2'b11, "word addr too wide");
    do_req(0, 1, 20'h00001, 16'hFFFF, 2'b00, "no byte enable");

    // R2 die switch on next cycle
    while (!req_ready) @(negedge clk);
    req_tgt = 0; req_write = 0; req_addr = 20'h5; req_be = 2'b11; req_valid = 1;
    @(negedge clk);
    req_tgt = 1; req_addr = 20'h7;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    repeat (12) @(negedge clk);
    chk(sr_sel_cyc - psr_rel_cyc == 1, "R2 next-cycle switch", sr_sel_cyc - psr_rel_cyc, 1);

    // R10 width pin frozen while busy
    sram_wide = 1;
    @(negedge clk);
    req_tgt = 1; req_write = 0; req_addr = 20'h9; req_be = 2'b11; req_valid = 1;
    @(negedge clk);
    req_valid = 0; sram_wide = 0;
    s0 = 0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (mem_sr_cio != 1'b1) s0++;
    end
    chk(s0 == 0, "R10 width held busy", s0, 0);
    repeat (6) @(negedge clk);
    chk(mem_sr_cio == 1'b0, "R10 width follows idle", mem_sr_cio, 0);

    for (int n = 0; n < 300; n++) begin
      logic t, w;
      logic [19:0] a;
      logic [1:0] b;
      if ($urandom % 10 == 0) sram_wide = ~sram_wide;
      t = $urandom % 2;
      w = $urandom % 2;
      b = 2'($urandom % 4);
      if (!t) a = ($urandom % 4 == 0) ? 20'($urandom) : 20'($urandom % 32);
      else begin
        a = 20'($urandom % 64);
        if ($urandom % 8 == 0) a[18 + ($urandom % 2)] = 1'b1;
        if (!sram_wide && $urandom % 4 != 0) b = 2'b01;
      end
      do_req(t, w, a, 16'($urandom), b, "random");
    end

    chk(v_excl == 0, "R2 exclusive", v_excl, 0);
    chk(v_stby == 0, "R1 enable pairs", v_stby, 0);
    chk(v_mode == 0, "R3 mode held", v_mode, 0);
    chk(v_drv == 0 && v_wr == 0, "R6 write gating", v_drv + v_wr, 0);
    chk(v_addr == 0, "R7 address moves", v_addr, 0);
    chk(v_oe == 0, "R8 oe only reads", v_oe, 0);
    chk(v_cio == 0, "R10 width stable", v_cio, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule